// File: doc/BRIEF.md
# Path AIS / Unequipped and K-Byte Inserter

This block sits on the outgoing byte stream of one channel, a byte-interleaved group of STS-1 signals, and overwrites selected bytes as software asks. For any single STS-1 it can force a path alarm indication signal (AIS) or the unequipped (UNEQ) pattern. For the whole channel it can write software-supplied K1/K2 values into a spare time slot, while the K1/K2 bytes of the first STS-1 still pass through.

The stream carries one byte per clock. A frame-start strobe marks the first byte of each frame, and the block works out every byte's position from it. Input byte `idx` of a frame lies in row `r = idx / (COLS_PER_STS*NUM_STS)` and interleaved column `j = idx % (COLS_PER_STS*NUM_STS)`. It belongs to STS-1 `s = j % NUM_STS` at per-STS column `c = j / NUM_STS`. Columns `c < 3` are transport overhead. Row 3 at columns 0, 1 and 2 holds the H1, H2 and H3 pointer bytes. Row 4 at columns 1 and 2 holds K1 and K2. Columns `c >= 3` are the payload envelope (SPE). Per-STS enables are written into a shadow set, and that set is copied into the active set on the frame-start byte.

Top module: `path_ovh_inserter`

## Requirements
- R1: Output is the input delayed by exactly one clock: `out_fs` equals `in_fs` of the previous cycle, and each `out_data` byte belongs to the input byte of the previous cycle.
- R2: A byte whose STS-1 has neither AIS nor UNEQ active, and which is not an overridden K position, is passed through unchanged.
- R3: With AIS active on STS-1 `s`, bytes of `s` at H1/H2/H3 (row 3, c = 0..2) and at every SPE column (c >= 3) leave as 8'hFF. Other STS-1s are unaffected.
- R4: With only UNEQ active on STS-1 `s`, H1 leaves as `UNEQ_H1` (default 8'h62), H2 leaves as `UNEQ_H2` (default 8'h0A), H3 passes unchanged, and every SPE byte leaves as 8'h00.
- R5: With AIS and UNEQ both active on one STS-1, the AIS pattern of R3 is produced.
- R6: Transport overhead bytes other than H1/H2/H3 (including E1, F1, E2 and the K bytes of every STS-1 not selected by R8) are never changed by AIS or UNEQ.
- R7: A write of the per-STS enables (`cfg_wr` with index `cfg_sts`, bits `cfg_ais`, `cfg_uneq`) takes effect from the first byte of the next frame whose `in_fs` falls after the write cycle. A write in the same cycle as `in_fs` waits one more frame. Indices >= NUM_STS are ignored.
- R8: With the K override enabled (`k_wr` loads `k_en_in`, `k1_in`, `k2_in`, effective from the next byte), row 4 bytes of STS-1 index `K_SLOT` (default 3, the fourth STS-1) leave as `k1` at c = 1 and as `k2` at c = 2. The K bytes of STS-1 index 0 pass unchanged.
- R9: With the K override disabled, the K positions of STS-1 `K_SLOT` pass unchanged.
- R10: While `rst_n` is low, `out_data` is 0 and `out_fs` is 0, and all AIS, UNEQ and K-override enables clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Incoming stream byte |
| in_fs | input | 1 | High on the first byte of a frame |
| cfg_wr | input | 1 | Write strobe for one STS-1's shadow enables |
| cfg_sts | input | STS_W | STS-1 index for the write |
| cfg_ais | input | 1 | AIS enable value to write |
| cfg_uneq | input | 1 | UNEQ enable value to write |
| k_wr | input | 1 | Write strobe for the K override |
| k_en_in | input | 1 | K override enable value |
| k1_in | input | 8 | K1 override byte |
| k2_in | input | 8 | K2 override byte |
| out_data | output | 8 | Outgoing stream byte |
| out_fs | output | 1 | Frame-start strobe aligned with out_data |

## Verification
Every output byte is due one clock after its input byte. The bench drives at a falling edge and compares at the next falling edge against the value it predicted for the byte driven one cycle earlier, so each comparison lands on the single register stage. Enable writes are recorded in a shadow model, which moves to an active model only when a frame-start byte is generated. A write made in the same cycle as that byte is applied after the byte's expectation is formed, so the frame-boundary rule is checked byte-exactly. The K override model updates after the write cycle's byte, which matches the new value showing from the next byte onward.

// File: rtl/path_ovh_pkg.sv
// Package: shared constants and the per-byte action code for the inserter.
// Assumes standard STS-1 overhead geometry (three overhead columns per STS-1).
package path_ovh_pkg;

    localparam int TOH_COLS = 3;   // overhead columns per STS-1
    localparam int PTR_ROW  = 3;   // row of H1/H2/H3
    localparam int APS_ROW  = 4;   // row of K1/K2

    typedef enum logic [2:0] {
        ACT_PASS,
        ACT_ONES,
        ACT_ZERO,
        ACT_H1,
        ACT_H2,
        ACT_K1,
        ACT_K2
    } byte_act_e;

endpackage

// File: rtl/poi_pos_tracker.sv
// Frame position tracker: gives row, per-STS column and STS index of the
// current input byte. The in_fs byte is position zero; a byte arrives every clock.
module poi_pos_tracker #(
    parameter int NUM_STS      = 12,
    parameter int ROWS         = 9,
    parameter int COLS_PER_STS = 90,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS_PER_STS),
    localparam int STS_W = $clog2(NUM_STS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fs,
    output logic [ROW_W-1:0] cur_row,
    output logic [COL_W-1:0] cur_col,
    output logic [STS_W-1:0] cur_sts
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS_PER_STS - 1);
    localparam logic [STS_W-1:0] STS_LAST = STS_W'(NUM_STS - 1);

    logic [ROW_W-1:0] cnt_row;
    logic [COL_W-1:0] cnt_col;
    logic [STS_W-1:0] cnt_sts;

    // Current position: restart at zero on the frame-start byte.
    always_comb begin
        cur_row = in_fs ? '0 : cnt_row;
        cur_col = in_fs ? '0 : cnt_col;
        cur_sts = in_fs ? '0 : cnt_sts;
    end

    // Advance to the next byte position: STS fastest, then column, then row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_row <= '0;
            cnt_col <= '0;
            cnt_sts <= '0;
        end else if (cur_sts != STS_LAST) begin
            cnt_row <= cur_row;
            cnt_col <= cur_col;
            cnt_sts <= cur_sts + 1'b1;
        end else begin
            cnt_sts <= '0;
            if (cur_col != COL_LAST) begin
                cnt_col <= cur_col + 1'b1;
                cnt_row <= cur_row;
            end else begin
                cnt_col <= '0;
                cnt_row <= (cur_row == ROW_LAST) ? '0 : cur_row + 1'b1;
            end
        end
    end

endmodule

// File: rtl/poi_cfg_regs.sv
// Configuration registers: per-STS shadow and active AIS/UNEQ enables and the
// channel K override. The shadow set is copied into the active set on in_fs.
// The enables seen by the frame-start byte are already the shadow values.
module poi_cfg_regs #(
    parameter int NUM_STS = 12,
    localparam int STS_W = $clog2(NUM_STS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_fs,
    input  logic               cfg_wr,
    input  logic [STS_W-1:0]   cfg_sts,
    input  logic               cfg_ais,
    input  logic               cfg_uneq,
    input  logic               k_wr,
    input  logic               k_en_in,
    input  logic [7:0]         k1_in,
    input  logic [7:0]         k2_in,
    output logic [NUM_STS-1:0] eff_ais,
    output logic [NUM_STS-1:0] eff_uneq,
    output logic               k_en,
    output logic [7:0]         k1,
    output logic [7:0]         k2
);

    logic [NUM_STS-1:0] sh_ais, sh_uneq, act_ais, act_uneq;

    for (genvar g = 0; g < NUM_STS; g++) begin : g_sts
        // Shadow enables for one STS-1, loaded by a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_ais[g]  <= 1'b0;
                sh_uneq[g] <= 1'b0;
            end else if (cfg_wr && (cfg_sts == STS_W'(g))) begin
                sh_ais[g]  <= cfg_ais;
                sh_uneq[g] <= cfg_uneq;
            end
        end

        // Active enables for one STS-1, refreshed at each frame start.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_ais[g]  <= 1'b0;
                act_uneq[g] <= 1'b0;
            end else if (in_fs) begin
                act_ais[g]  <= sh_ais[g];
                act_uneq[g] <= sh_uneq[g];
            end
        end
    end

    // Enables applying to the current byte.
    always_comb begin
        eff_ais  = in_fs ? sh_ais  : act_ais;
        eff_uneq = in_fs ? sh_uneq : act_uneq;
    end

    // Channel K override value, updated immediately on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_en <= 1'b0;
            k1   <= '0;
            k2   <= '0;
        end else if (k_wr) begin
            k_en <= k_en_in;
            k1   <= k1_in;
            k2   <= k2_in;
        end
    end

endmodule

// File: rtl/poi_byte_editor.sv
// Byte editor: classifies the current byte by position and enables, then
// registers the replaced or passed byte with the aligned frame strobe.
// Assumes the position and enables describe the byte on in_data this cycle.
module poi_byte_editor
    import path_ovh_pkg::*;
#(
    parameter int          NUM_STS      = 12,
    parameter int          ROWS         = 9,
    parameter int          COLS_PER_STS = 90,
    parameter int          K_SLOT       = 3,
    parameter logic [7:0]  UNEQ_H1      = 8'h62,
    parameter logic [7:0]  UNEQ_H2      = 8'h0A,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS_PER_STS),
    localparam int STS_W = $clog2(NUM_STS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         in_data,
    input  logic               in_fs,
    input  logic [ROW_W-1:0]   cur_row,
    input  logic [COL_W-1:0]   cur_col,
    input  logic [STS_W-1:0]   cur_sts,
    input  logic [NUM_STS-1:0] eff_ais,
    input  logic [NUM_STS-1:0] eff_uneq,
    input  logic               k_en,
    input  logic [7:0]         k1,
    input  logic [7:0]         k2,
    output logic [7:0]         out_data,
    output logic               out_fs
);

    byte_act_e act;
    logic      is_spe, is_ptr, is_kslot, ais_on, uneq_on;
    logic [7:0] nxt;

    // Decode the byte's role and the action to take.
    always_comb begin
        is_spe   = cur_col >= COL_W'(TOH_COLS);
        is_ptr   = (cur_row == ROW_W'(PTR_ROW)) && !is_spe;
        is_kslot = k_en && (cur_sts == STS_W'(K_SLOT)) && (cur_row == ROW_W'(APS_ROW));
        ais_on   = eff_ais[cur_sts];
        uneq_on  = eff_uneq[cur_sts];
        act      = ACT_PASS;
        if (is_kslot && cur_col == COL_W'(1)) begin
            act = ACT_K1;
        end else if (is_kslot && cur_col == COL_W'(2)) begin
            act = ACT_K2;
        end else if (ais_on && (is_spe || is_ptr)) begin
            act = ACT_ONES;
        end else if (uneq_on && is_spe) begin
            act = ACT_ZERO;
        end else if (uneq_on && is_ptr && cur_col == COL_W'(0)) begin
            act = ACT_H1;
        end else if (uneq_on && is_ptr && cur_col == COL_W'(1)) begin
            act = ACT_H2;
        end
    end

    // Select the outgoing byte for the chosen action.
    always_comb begin
        unique case (act)
            ACT_ONES: nxt = 8'hFF;
            ACT_ZERO: nxt = 8'h00;
            ACT_H1:   nxt = UNEQ_H1;
            ACT_H2:   nxt = UNEQ_H2;
            ACT_K1:   nxt = k1;
            ACT_K2:   nxt = k2;
            default:  nxt = in_data;
        endcase
    end

    // One-cycle output stage for data and frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_fs   <= 1'b0;
        end else begin
            out_data <= nxt;
            out_fs   <= in_fs;
        end
    end

endmodule

// File: rtl/path_ovh_inserter.sv
// Top: path AIS/UNEQ and K-byte inserter for one byte-interleaved channel.
// Assumes one byte per clock and an in_fs strobe on every frame's first byte.
module path_ovh_inserter #(
    parameter int          NUM_STS      = 12,
    parameter int          ROWS         = 9,
    parameter int          COLS_PER_STS = 90,
    parameter int          K_SLOT       = 3,
    parameter logic [7:0]  UNEQ_H1      = 8'h62,
    parameter logic [7:0]  UNEQ_H2      = 8'h0A,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS_PER_STS),
    localparam int STS_W = $clog2(NUM_STS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_fs,
    input  logic             cfg_wr,
    input  logic [STS_W-1:0] cfg_sts,
    input  logic             cfg_ais,
    input  logic             cfg_uneq,
    input  logic             k_wr,
    input  logic             k_en_in,
    input  logic [7:0]       k1_in,
    input  logic [7:0]       k2_in,
    output logic [7:0]       out_data,
    output logic             out_fs
);

    logic [ROW_W-1:0]   cur_row;
    logic [COL_W-1:0]   cur_col;
    logic [STS_W-1:0]   cur_sts;
    logic [NUM_STS-1:0] eff_ais, eff_uneq;
    logic               k_en;
    logic [7:0]         k1, k2;

    poi_pos_tracker #(
        .NUM_STS(NUM_STS), .ROWS(ROWS), .COLS_PER_STS(COLS_PER_STS)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .in_fs(in_fs),
        .cur_row(cur_row), .cur_col(cur_col), .cur_sts(cur_sts)
    );

    poi_cfg_regs #(
        .NUM_STS(NUM_STS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .in_fs(in_fs),
        .cfg_wr(cfg_wr), .cfg_sts(cfg_sts), .cfg_ais(cfg_ais), .cfg_uneq(cfg_uneq),
        .k_wr(k_wr), .k_en_in(k_en_in), .k1_in(k1_in), .k2_in(k2_in),
        .eff_ais(eff_ais), .eff_uneq(eff_uneq),
        .k_en(k_en), .k1(k1), .k2(k2)
    );

    poi_byte_editor #(
        .NUM_STS(NUM_STS), .ROWS(ROWS), .COLS_PER_STS(COLS_PER_STS),
        .K_SLOT(K_SLOT), .UNEQ_H1(UNEQ_H1), .UNEQ_H2(UNEQ_H2)
    ) u_edit (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_fs(in_fs),
        .cur_row(cur_row), .cur_col(cur_col), .cur_sts(cur_sts),
        .eff_ais(eff_ais), .eff_uneq(eff_uneq),
        .k_en(k_en), .k1(k1), .k2(k2),
        .out_data(out_data), .out_fs(out_fs)
    );

endmodule

// File: rtl/path_ovh_inserter_chk.sv
// Checker: relates the output stage to the tracker position and the
// configuration enables one clock earlier. Bound into path_ovh_inserter.
module path_ovh_inserter_chk #(
    parameter int NUM_STS = 12,
    parameter int ROW_W   = 4,
    parameter int COL_W   = 7,
    parameter int STS_W   = 4,
    parameter int K_SLOT  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         in_data,
    input logic               in_fs,
    input logic [7:0]         out_data,
    input logic               out_fs,
    input logic [ROW_W-1:0]   cur_row,
    input logic [COL_W-1:0]   cur_col,
    input logic [STS_W-1:0]   cur_sts,
    input logic [NUM_STS-1:0] eff_ais,
    input logic [NUM_STS-1:0] eff_uneq,
    input logic               k_en,
    input logic [7:0]         k1
);

    logic armed;
    logic c_spe, c_ptr, c_kpos, c_ais, c_uneq;

    // Arm once one clock has passed since reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Position class of the current input byte.
    always_comb begin
        c_spe  = cur_col >= COL_W'(3);
        c_ptr  = (cur_row == ROW_W'(3)) && !c_spe;
        c_kpos = k_en && (cur_sts == STS_W'(K_SLOT)) && (cur_row == ROW_W'(4))
                 && (cur_col == COL_W'(1) || cur_col == COL_W'(2));
        c_ais  = eff_ais[cur_sts];
        c_uneq = eff_uneq[cur_sts];
    end

    p_fs_delay_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        out_fs == $past(in_fs));

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!c_ais && !c_uneq && !c_kpos) |-> out_data == $past(in_data));

    p_ais_ones_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(c_ais && (c_spe || c_ptr)) |-> out_data == 8'hFF);

    p_uneq_zero_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!c_ais && c_uneq && c_spe) |-> out_data == 8'h00);

    p_ais_wins_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(c_ais && c_uneq && c_spe) |-> out_data == 8'hFF);

    p_toh_kept_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!c_spe && !c_ptr && !c_kpos) |-> out_data == $past(in_data));

    p_hold_mid_frame_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !in_fs |-> ($stable(eff_ais) && $stable(eff_uneq)));

    p_k1_insert_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(c_kpos && cur_col == COL_W'(1)) |-> out_data == $past(k1));

    // R10: output register is cleared while reset is held.
    p_reset_clear_r10: assert property (@(posedge clk)
        $past(!rst_n) && armed == 1'b0 && !rst_n |-> (out_data == 8'h00 && !out_fs));

endmodule

bind path_ovh_inserter path_ovh_inserter_chk #(
    .NUM_STS(NUM_STS), .ROW_W(ROW_W), .COL_W(COL_W), .STS_W(STS_W), .K_SLOT(K_SLOT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_fs(in_fs),
    .out_data(out_data), .out_fs(out_fs),
    .cur_row(cur_row), .cur_col(cur_col), .cur_sts(cur_sts),
    .eff_ais(eff_ais), .eff_uneq(eff_uneq), .k_en(k_en), .k1(k1)
);

// File: tb/path_ovh_inserter_bench.sv
`timescale 1ns/1ps
// Bench: streams six full frames through the inserter, changing the enables
// and the K override on a schedule, and predicts every output byte.
module path_ovh_inserter_bench;

    localparam int NS    = 12;
    localparam int ROWS  = 9;
    localparam int CPS   = 90;
    localparam int KS    = 3;
    localparam int LINE  = CPS * NS;
    localparam int FRAME = LINE * ROWS;
    localparam int NFR   = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_data;
    logic       in_fs;
    logic       cfg_wr;
    logic [3:0] cfg_sts;
    logic       cfg_ais, cfg_uneq;
    logic       k_wr, k_en_in;
    logic [7:0] k1_in, k2_in;
    logic [7:0] out_data;
    logic       out_fs;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    bit  m_sh_ais[NS], m_sh_uneq[NS], m_act_ais[NS], m_act_uneq[NS];
    bit  m_ken;
    logic [7:0] m_k1, m_k2;

    bit         have_prev;
    logic [7:0] exp_data;
    logic       exp_fs;
    string      exp_tag;

    always #2.5 clk = ~clk;

    path_ovh_inserter u_path_ovh_inserter (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_fs(in_fs),
        .cfg_wr(cfg_wr), .cfg_sts(cfg_sts), .cfg_ais(cfg_ais), .cfg_uneq(cfg_uneq),
        .k_wr(k_wr), .k_en_in(k_en_in), .k1_in(k1_in), .k2_in(k2_in),
        .out_data(out_data), .out_fs(out_fs)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            if (n_fail <= 20)
                $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr_sts(input int s, input bit a, input bit u);
        cfg_wr = 1'b1; cfg_sts = 4'(s); cfg_ais = a; cfg_uneq = u;
        if (s < NS) begin
            m_sh_ais[s]  = a;
            m_sh_uneq[s] = u;
        end
    endtask

    task automatic wr_k(input bit e, input logic [7:0] a, input logic [7:0] b);
        k_wr = 1'b1; k_en_in = e; k1_in = a; k2_in = b;
        m_ken = e; m_k1 = a; m_k2 = b;
    endtask

    // Write schedule; applied to the model after the byte's expectation.
    task automatic schedule(input int f, input int idx);
        if (f == 0 && idx == 50) wr_sts(2, 1, 0);
        if (f == 0 && idx == 51) wr_sts(5, 0, 1);
        if (f == 0 && idx == 52) wr_sts(7, 1, 1);       // both: R5
        if (f == 0 && idx == 53) wr_k(1, 8'hA5, 8'h3C); // R8
        if (f == 0 && idx == 54) wr_sts(14, 1, 1);      // out of range: R7
        if (f == 1 && idx == 60) wr_sts(2, 0, 0);
        if (f == 1 && idx == 61) wr_k(0, 8'h11, 8'h22); // R9
        if (f == 2 && idx == 0)  wr_sts(11, 0, 1);      // same cycle as fs: R7
        if (f == 3 && idx >= 70 && idx < 70 + NS) wr_sts(idx - 70, 1, 0);
        if (f == 4 && idx == 10) wr_k(1, 8'h00, 8'hFF);
    endtask

    function automatic logic [7:0] predict(input int idx, input logic [7:0] din, output string tag);
        int r, j, s, c;
        logic [7:0] v;
        r = idx / LINE; j = idx % LINE; s = j % NS; c = j / NS;
        v = din; tag = "R2";
        if (m_ken && s == KS && r == 4 && (c == 1 || c == 2)) begin
            v = (c == 1) ? m_k1 : m_k2; tag = "R8";
        end else if (s == KS && r == 4 && (c == 1 || c == 2)) begin
            tag = "R9";
        end else if (c >= 3 || r == 3) begin
            if (m_act_ais[s]) begin
                v = 8'hFF; tag = m_act_uneq[s] ? "R5" : "R3";
            end else if (m_act_uneq[s]) begin
                tag = "R4";
                if (c >= 3)      v = 8'h00;
                else if (c == 0) v = 8'h62;
                else if (c == 1) v = 8'h0A;
            end
        end else begin
            tag = "R6";
        end
        if (m_sh_ais[s] != m_act_ais[s] || m_sh_uneq[s] != m_act_uneq[s])
            tag = {tag, "/R7"};
        return v;
    endfunction

    initial begin
        rst_n = 1'b0; in_data = '0; in_fs = 1'b0;
        cfg_wr = 1'b0; cfg_sts = '0; cfg_ais = 1'b0; cfg_uneq = 1'b0;
        k_wr = 1'b0; k_en_in = 1'b0; k1_in = '0; k2_in = '0;
        m_ken = 1'b0; m_k1 = '0; m_k2 = '0;
        for (int i = 0; i < NS; i++) begin
            m_sh_ais[i] = 0; m_sh_uneq[i] = 0; m_act_ais[i] = 0; m_act_uneq[i] = 0;
        end
        have_prev = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 data", out_data, 8'h00);
        check("R10 fs", {7'd0, out_fs}, 8'h00);
        rst_n = 1'b1;
        for (int f = 0; f < NFR; f++) begin
            for (int idx = 0; idx < FRAME; idx++) begin
                @(negedge clk);
                if (have_prev) begin
                    check(exp_tag, out_data, exp_data);
                    check("R1 fs", {7'd0, out_fs}, {7'd0, exp_fs});
                end
                cfg_wr = 1'b0; k_wr = 1'b0;
                in_fs   = (idx == 0);
                in_data = 8'((idx * 37 + f * 11 + 5) & 255);
                if (idx == 0) begin
                    for (int i = 0; i < NS; i++) begin
                        m_act_ais[i]  = m_sh_ais[i];
                        m_act_uneq[i] = m_sh_uneq[i];
                    end
                end
                exp_data  = predict(idx, in_data, exp_tag);
                exp_fs    = in_fs;
                have_prev = 1'b1;
                schedule(f, idx);
            end
        end
        @(negedge clk);
        check(exp_tag, out_data, exp_data);
        check("R1 fs", {7'd0, out_fs}, {7'd0, exp_fs});
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule